// File: doc/BRIEF.md
# Long-word store bus-cycle sequencer

This block performs the destination half of a 32-bit move on a processor whose data bus is 16 bits wide. A decoder starts it with the destination addressing mode, the register number, the 32-bit value to store, and the context the address needs: the current address-register contents, the fetch pointer, the extension words already prefetched, and a precomputed index value. The block then issues a fixed, mode-dependent series of bus operations. Each operation is an idle cycle, an instruction-word fetch, a high-half write or a low-half write, and each comes with its address and data.

Operations are offered one at a time under a valid/ready handshake. The sequence advances only when an operation is accepted. The halfword writes can come in either order, and the fetch and idle cycles move around them; both depend on the addressing mode. Modes that change a register (register direct, postincrement, predecrement) report the final register value with a one-cycle write strobe. That strobe coincides with the completion pulse.

Top module: `lstore_seq`

## Requirements
- R1: While op_valid is high and op_ready is low, op_kind, op_addr and op_data hold steady. The sequence moves to its next operation only on a cycle with op_valid and op_ready both high.
- R2: Mode codes and operation codes are fixed as follows.
  - dst_mode 0 (data register direct) and 1 (address register direct) issue a single fetch and no memory write.
  - At completion they assert reg_we with reg_wdata equal to value.
  - reg_sel is {0, dst_reg} for mode 0 and {1, dst_reg} for every other mode.
  - op_kind codes are: 0 idle, 1 fetch, 2 high-half write, 3 low-half write.
- R3: Modes 2 (indirect) and 3 (postincrement) issue: high write at A, low write at A+2, fetch. Mode 3 writes A+4 back to the register. Mode 2 leaves reg_we low.
- R4: Mode 4 (predecrement) issues: fetch, low write at A-2, high write at A-4. No fetch follows. The register receives A-4.
- R5: Modes 5 (A plus sign-extended ext_word) and 7 (sign-extended ext_word alone) issue: fetch, high write at EA, low write at EA+2, fetch.
- R6: Modes 9 (fetch pointer with 16-bit displacement) and 10 (fetch pointer with index) use pc_in-2 as their base. Otherwise they behave like modes 5 and 6.
- R7: Modes 6 and 10 have effective address base + sign-extended ext_word[7:0] + index_val. They issue: idle (address 0), fetch, high write, low write, fetch.
- R8: Mode 8 (absolute long, address ext_long) depends on src_simple.
  - With src_simple high it issues: fetch, fetch, high write, low write, fetch.
  - With src_simple low it issues: fetch, high write, low write, fetch, fetch.
- R9: The first fetch of a sequence addresses pc_in, and each later fetch is 2 higher. High writes carry value[31:16]; low writes carry value[15:0]. All other operations carry data 0.
- R10: After reset no operation is offered. done pulses for one cycle, on the cycle after the final operation is accepted, with op_valid low. A start while a sequence runs is ignored.
- R11: All address arithmetic, including register write-back values, wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| dst_mode | input | 4 | Destination addressing mode code |
| dst_reg | input | 3 | Destination register number |
| src_simple | input | 1 | Source was register direct or immediate |
| value | input | 32 | Value to store |
| areg_in | input | 32 | Current address-register contents |
| pc_in | input | 32 | Fetch pointer for the next instruction word |
| ext_word | input | 16 | First extension word |
| ext_long | input | 32 | Absolute-long address |
| index_val | input | 32 | Precomputed index value |
| op_valid | output | 1 | A bus operation is offered |
| op_ready | input | 1 | The offered operation is accepted |
| op_kind | output | 2 | Operation code |
| op_addr | output | 32 | Operation address |
| op_data | output | 16 | Write data |
| reg_we | output | 1 | Register write-back strobe |
| reg_sel | output | 4 | Register written: {address flag, number} |
| reg_wdata | output | 32 | Register write-back value |
| done | output | 1 | Sequence complete pulse |

## Verification
Two events can fall in the same clock. The first is acceptance of the final operation together with the end of the sequence: busy drops, the completion pulse is scheduled and the register strobe is raised. The second is acceptance of a fetch together with the advance of the fetch pointer. The bench provokes both by holding op_ready low for irregular stretches and raising it on exactly the final or a fetch operation. A behavioural reference queue, built from the mode rules, judges every offered operation, and the bench confirms that done and reg_we appear one cycle later with nothing offered. A start pulse injected mid-sequence with a different mode must leave the remaining operations unchanged.

// File: rtl/lstore_pkg.sv
package lstore_pkg;
  localparam int AW      = 32;
  localparam int HW      = 16;
  localparam int MAX_OPS = 5;
  localparam int SW      = $clog2(MAX_OPS);

  typedef enum logic [3:0] {
    M_DREG    = 4'd0,
    M_AREG    = 4'd1,
    M_IND     = 4'd2,
    M_POSTINC = 4'd3,
    M_PREDEC  = 4'd4,
    M_DISP16  = 4'd5,
    M_IDX8    = 4'd6,
    M_ABS_S   = 4'd7,
    M_ABS_L   = 4'd8,
    M_PC_DISP = 4'd9,
    M_PC_IDX  = 4'd10
  } dmode_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FETCH = 2'd1,
    OP_WR_HI = 2'd2,
    OP_WR_LO = 2'd3
  } opk_t;

  function automatic logic [AW-1:0] sext16(input logic [15:0] w);
    return {{(AW-16){w[15]}}, w};
  endfunction

  function automatic logic [AW-1:0] sext8(input logic [7:0] b);
    return {{(AW-8){b[7]}}, b};
  endfunction

  // Address of the high half (the lower of the two words).
  function automatic logic [AW-1:0] ea_of(input dmode_t m, input logic [AW-1:0] a,
                                          input logic [AW-1:0] pc, input logic [15:0] ext,
                                          input logic [AW-1:0] xl, input logic [AW-1:0] idx);
    logic [AW-1:0] pcb;
    pcb = pc - AW'(2);
    case (m)
      M_PREDEC:  return a - AW'(4);
      M_DISP16:  return a + sext16(ext);
      M_IDX8:    return a + sext8(ext[7:0]) + idx;
      M_ABS_S:   return sext16(ext);
      M_ABS_L:   return xl;
      M_PC_DISP: return pcb + sext16(ext);
      M_PC_IDX:  return pcb + sext8(ext[7:0]) + idx;
      default:   return a;
    endcase
  endfunction

  function automatic logic [AW-1:0] reg_after(input dmode_t m, input logic [AW-1:0] a,
                                              input logic [AW-1:0] v);
    case (m)
      M_POSTINC: return a + AW'(4);
      M_PREDEC:  return a - AW'(4);
      default:   return v;
    endcase
  endfunction
endpackage

// File: rtl/lstore_plan.sv
module lstore_plan
  import lstore_pkg::*;
(
  input  dmode_t                 mode,
  input  logic                   simple,
  output opk_t [MAX_OPS-1:0]     ops,
  output logic [SW-1:0]          last,
  output logic                   upd
);
  always_comb begin
    for (int i = 0; i < MAX_OPS; i++) ops[i] = OP_IDLE;
    last = '0;
    upd  = 1'b0;
    case (mode)
      M_IND, M_POSTINC: begin
        ops[0] = OP_WR_HI; ops[1] = OP_WR_LO; ops[2] = OP_FETCH;
        last = SW'(2);
        upd  = (mode == M_POSTINC);
      end
      M_PREDEC: begin
        ops[0] = OP_FETCH; ops[1] = OP_WR_LO; ops[2] = OP_WR_HI;
        last = SW'(2);
        upd  = 1'b1;
      end
      M_DISP16, M_ABS_S, M_PC_DISP: begin
        ops[0] = OP_FETCH; ops[1] = OP_WR_HI; ops[2] = OP_WR_LO; ops[3] = OP_FETCH;
        last = SW'(3);
      end
      M_IDX8, M_PC_IDX: begin
        ops[0] = OP_IDLE;  ops[1] = OP_FETCH; ops[2] = OP_WR_HI;
        ops[3] = OP_WR_LO; ops[4] = OP_FETCH;
        last = SW'(4);
      end
      M_ABS_L: begin
        ops[0] = OP_FETCH;
        if (simple) begin
          ops[1] = OP_FETCH; ops[2] = OP_WR_HI; ops[3] = OP_WR_LO; ops[4] = OP_FETCH;
        end else begin
          ops[1] = OP_WR_HI; ops[2] = OP_WR_LO; ops[3] = OP_FETCH; ops[4] = OP_FETCH;
        end
        last = SW'(4);
      end
      default: begin
        ops[0] = OP_FETCH;
        upd    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lstore_addr.sv
module lstore_addr
  import lstore_pkg::*;
(
  input  dmode_t          mode,
  input  logic [AW-1:0]   areg,
  input  logic [AW-1:0]   pc,
  input  logic [15:0]     ext,
  input  logic [AW-1:0]   ext_l,
  input  logic [AW-1:0]   idx,
  input  logic [AW-1:0]   val,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   reg_next
);
  assign ea       = ea_of(mode, areg, pc, ext, ext_l, idx);
  assign reg_next = reg_after(mode, areg, val);
endmodule

// File: rtl/lstore_seq.sv
module lstore_seq
  import lstore_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    dst_mode,
  input  logic [2:0]    dst_reg,
  input  logic          src_simple,
  input  logic [31:0]   value,
  input  logic [31:0]   areg_in,
  input  logic [31:0]   pc_in,
  input  logic [15:0]   ext_word,
  input  logic [31:0]   ext_long,
  input  logic [31:0]   index_val,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [1:0]    op_kind,
  output logic [31:0]   op_addr,
  output logic [15:0]   op_data,
  output logic          reg_we,
  output logic [3:0]    reg_sel,
  output logic [31:0]   reg_wdata,
  output logic          done
);
  dmode_t             mode_in;
  opk_t [MAX_OPS-1:0] plan_ops;
  logic [SW-1:0]      plan_last;
  logic               plan_upd;
  logic [AW-1:0]      calc_ea, calc_reg;

  assign mode_in = dmode_t'(dst_mode);

  lstore_plan u_plan (
    .mode(mode_in), .simple(src_simple),
    .ops(plan_ops), .last(plan_last), .upd(plan_upd)
  );

  lstore_addr u_addr (
    .mode(mode_in), .areg(areg_in), .pc(pc_in), .ext(ext_word),
    .ext_l(ext_long), .idx(index_val), .val(value),
    .ea(calc_ea), .reg_next(calc_reg)
  );

  logic               busy;
  logic [SW-1:0]      step;
  opk_t [MAX_OPS-1:0] l_ops;
  logic [SW-1:0]      l_last;
  logic               l_upd;
  dmode_t             l_mode;
  logic [AW-1:0]      l_ea, l_reg, pf_addr;
  logic [AW-1:0]      l_val;

  // Named internal events used by the assertions.
  opk_t cur_kind;
  logic accept, final_accept, pf_fire;
  assign cur_kind     = l_ops[step];
  assign accept       = busy && op_ready;
  assign final_accept = accept && (step == l_last);
  assign pf_fire      = accept && (cur_kind == OP_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      step    <= '0;
      done    <= 1'b0;
      reg_we  <= 1'b0;
      l_ops   <= '0;
      l_last  <= '0;
      l_upd   <= 1'b0;
      l_mode  <= M_DREG;
      l_ea    <= '0;
      l_reg   <= '0;
      l_val   <= '0;
      pf_addr <= '0;
      reg_sel <= '0;
    end else begin
      done   <= 1'b0;
      reg_we <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          step    <= '0;
          l_ops   <= plan_ops;
          l_last  <= plan_last;
          l_upd   <= plan_upd;
          l_mode  <= mode_in;
          l_ea    <= calc_ea;
          l_reg   <= calc_reg;
          l_val   <= value;
          pf_addr <= pc_in;
          reg_sel <= {(mode_in != M_DREG), dst_reg};
        end
      end else if (accept) begin
        if (pf_fire) pf_addr <= pf_addr + AW'(2);
        if (final_accept) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          reg_we <= l_upd;
        end else begin
          step <= step + SW'(1);
        end
      end
    end
  end

  assign op_valid  = busy;
  assign op_kind   = cur_kind;
  assign reg_wdata = l_reg;

  always_comb begin
    op_addr = '0;
    op_data = '0;
    case (cur_kind)
      OP_FETCH: op_addr = pf_addr;
      OP_WR_HI: begin op_addr = l_ea;           op_data = l_val[31:16]; end
      OP_WR_LO: begin op_addr = l_ea + AW'(2);  op_data = l_val[15:0];  end
      default: ;
    endcase
  end

  // R1: an offered operation stays put until taken
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_addr) && $stable(op_data));

  // R10: completion follows an acceptance and nothing is offered with it
  a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_valid && op_ready));
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !op_valid);

  // R2: write-back strobe only together with completion
  a_r2_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> done);

  // R4: predecrement ends on the high-half write, no trailing fetch
  a_r4_predec_tail: assert property (@(posedge clk) disable iff (!rst_n)
    final_accept && l_mode == M_PREDEC |-> op_kind == 2'd2);

  // R9: a taken fetch moves the next fetch address up by two
  a_r9_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    pf_fire && !final_accept |=> $past(pf_addr) + 32'd2 == pf_addr);
endmodule

// File: tb/lstore_seq_test.sv
module lstore_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  dst_mode = '0;
  logic [2:0]  dst_reg = '0;
  logic        src_simple = 1'b0;
  logic [31:0] value = '0, areg_in = '0, pc_in = '0, ext_long = '0, index_val = '0;
  logic [15:0] ext_word = '0;
  logic        op_valid, op_ready = 1'b0;
  logic [1:0]  op_kind;
  logic [31:0] op_addr;
  logic [15:0] op_data;
  logic        reg_we;
  logic [3:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  lstore_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_mode(dst_mode), .dst_reg(dst_reg),
    .src_simple(src_simple), .value(value), .areg_in(areg_in), .pc_in(pc_in),
    .ext_word(ext_word), .ext_long(ext_long), .index_val(index_val),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .done(done)
  );

  int          q_kind[$];
  logic [31:0] q_addr[$];
  logic [15:0] q_data[$];

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, want);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
      finish_up();
    end
  end

  // Reference: build the expected operation stream from the mode rules.
  task automatic build(input int m, input logic [31:0] a, input logic [31:0] pc,
                       input logic [15:0] ext, input logic [31:0] xl,
                       input logic [31:0] idx, input logic [31:0] v, input bit simple);
    logic [31:0] pfa, hi_at, lo_at;
    string order;
    pfa = pc;
    q_kind.delete(); q_addr.delete(); q_data.delete();
    case (m)
      2, 3:    begin hi_at = a;                                   order = "HLF";   end
      4:       begin hi_at = a - 4;                               order = "FLH";   end
      5:       begin hi_at = a + {{16{ext[15]}}, ext};            order = "FHLF";  end
      7:       begin hi_at = {{16{ext[15]}}, ext};                order = "FHLF";  end
      9:       begin hi_at = (pc - 2) + {{16{ext[15]}}, ext};     order = "FHLF";  end
      6:       begin hi_at = a + {{24{ext[7]}}, ext[7:0]} + idx;  order = "IFHLF"; end
      10:      begin hi_at = (pc - 2) + {{24{ext[7]}}, ext[7:0]} + idx; order = "IFHLF"; end
      8:       begin hi_at = xl; order = simple ? "FFHLF" : "FHLFF"; end
      default: begin hi_at = 0;  order = "F"; end
    endcase
    lo_at = hi_at + 2;
    foreach (order[i]) begin
      case (order[i])
        "F": begin q_kind.push_back(1); q_addr.push_back(pfa); q_data.push_back(0); pfa += 2; end
        "H": begin q_kind.push_back(2); q_addr.push_back(hi_at); q_data.push_back(v[31:16]); end
        "L": begin q_kind.push_back(3); q_addr.push_back(lo_at); q_data.push_back(v[15:0]); end
        default: begin q_kind.push_back(0); q_addr.push_back(0); q_data.push_back(0); end
      endcase
    end
  endtask

  task automatic run(input string req, input int m, input logic [2:0] r,
                     input logic [31:0] a, input logic [31:0] pc, input logic [15:0] ext,
                     input logic [31:0] xl, input logic [31:0] idx, input logic [31:0] v,
                     input bit simple, input logic [7:0] pat, input bit poke);
    bit exp_we;
    logic [31:0] exp_reg;
    int guard = 0;
    int k = 0;
    build(m, a, pc, ext, xl, idx, v, simple);
    exp_we  = (m == 0 || m == 1 || m == 3 || m == 4);
    exp_reg = (m == 3) ? a + 4 : (m == 4) ? a - 4 : v;
    @(negedge clk);
    dst_mode = 4'(m); dst_reg = r; areg_in = a; pc_in = pc; ext_word = ext;
    ext_long = xl; index_val = idx; value = v; src_simple = simple; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (done) break;
      if (poke && k == 1) begin
        start = 1'b1; dst_mode = 4'd4; areg_in = 32'h0BAD_0000; pc_in = 32'h0; value = 32'hFFFF_FFFF;
      end else start = 1'b0;
      if (op_valid) begin
        if (q_kind.size() == 0) check({req, " extra op"}, 64'(op_kind), 64'hFF);
        else begin
          check({req, " kind"}, 64'(op_kind), 64'(q_kind[0]));
          check({req, " addr"}, 64'(op_addr), 64'(q_addr[0]));
          check({req, " data"}, 64'(op_data), 64'(q_data[0]));
        end
        op_ready = pat[k % 8];
        if (op_ready && q_kind.size() > 0) begin
          void'(q_kind.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
        end
        k++;
      end else op_ready = 1'b0;
      guard++;
      if (guard > 200) begin
        check({req, " timeout"}, 64'(guard), 64'd0);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    op_ready = 1'b0;
    // R10: done with nothing offered, all expected ops consumed
    check({req, " R10 done quiet"}, 64'(op_valid), 64'd0);
    check({req, " R10 all ops"}, 64'(q_kind.size()), 64'd0);
    check({req, " R2 reg_we"}, 64'(reg_we), 64'(exp_we));
    if (exp_we) begin
      check({req, " R2 reg_wdata"}, 64'(reg_wdata), 64'(exp_reg));
      check({req, " R2 reg_sel"}, 64'(reg_sel), 64'({(m != 0), r}));
    end
    @(negedge clk);
    check({req, " R10 done one cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset valid", 64'(op_valid), 64'd0);
    check("R10 reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", 64'(op_valid), 64'd0);

    run("R2 dreg", 0, 3'd3, 32'h1000, 32'h2000, 16'h0, 0, 0, 32'hCAFE_BABE, 0, 8'hFF, 0);
    run("R2 areg", 1, 3'd5, 32'h1000, 32'h2000, 16'h0, 0, 0, 32'h1234_5678, 0, 8'b1010_0110, 0);
    run("R3 ind", 2, 3'd1, 32'h0000_4000, 32'h100, 16'h0, 0, 0, 32'hA1B2_C3D4, 0, 8'hFF, 0);
    run("R3 postinc R1", 3, 3'd2, 32'h0000_5000, 32'h200, 16'h0, 0, 0, 32'h0102_0304, 0, 8'b0101_1001, 0);
    run("R4 predec", 4, 3'd7, 32'h0000_6000, 32'h300, 16'h0, 0, 0, 32'hDEAD_BEEF, 0, 8'b1100_1101, 0);
    run("R5 disp16", 5, 3'd0, 32'h0000_7000, 32'h400, 16'hFFF0, 0, 0, 32'h5555_AAAA, 0, 8'hFF, 0);
    run("R5 abs_s", 7, 3'd0, 32'h0, 32'h500, 16'h8002, 0, 0, 32'h1111_2222, 0, 8'b0110_1011, 0);
    run("R7 idx8", 6, 3'd4, 32'h0000_8000, 32'h600, 16'h00FE, 0, 32'h10, 32'h7777_8888, 0, 8'b1001_1111, 0);
    run("R6 pc_disp", 9, 3'd0, 32'h0, 32'h0000_0700, 16'h0010, 0, 0, 32'h9999_0000, 0, 8'hFF, 0);
    run("R6 pc_idx R7", 10, 3'd0, 32'h0, 32'h0000_0800, 16'h0080, 0, 32'h200, 32'h0000_FFFF, 0, 8'b1011_0101, 0);
    run("R8 abs_l simple", 8, 3'd0, 32'h0, 32'h900, 16'h0, 32'h00FF_0010, 0, 32'hABCD_EF01, 1, 8'b1110_0111, 0);
    run("R8 abs_l mem", 8, 3'd0, 32'h0, 32'hA00, 16'h0, 32'h00FF_0020, 0, 32'h2468_ACE0, 0, 8'hFF, 0);
    run("R11 postinc wrap", 3, 3'd6, 32'hFFFF_FFFE, 32'hB00, 16'h0, 0, 0, 32'h1357_9BDF, 0, 8'hFF, 0);
    run("R11 predec wrap", 4, 3'd1, 32'h0000_0002, 32'hC00, 16'h0, 0, 0, 32'hFEDC_BA98, 0, 8'b0111_0111, 0);
    run("R10 start ignored R9", 6, 3'd2, 32'h0000_9000, 32'hD00, 16'h0004, 0, 32'h8, 32'h0F0F_F0F0, 0, 8'b0010_1011, 1);
    finish_up();
  end
endmodule